// File: doc/BRIEF.md
# Auxiliary-Channel Interrupt Triplet Register

This block is the interrupt register of a display auxiliary-channel controller. It gathers single-cycle event pulses from the transfer engine: one completion event and five kinds of failure. Each event is caught in a sticky status bit. A single interrupt line goes high while any enabled source has its status bit set.

Each source owns three adjacent bits of one 32-bit word. The lowest of the three is its status, the next is its clear strobe, and the highest is its enable. Software therefore uses one register for everything. A single write can clear any set of sources and re-enable any other set in one access. A read returns every status bit and every enable bit at once.

Alongside the interrupt line, the block drives a completion flag. Driver code polls this flag when interrupts are not yet in use. The flag is high when the done bit or any failure bit is set, whatever the enables are.

Top module: `aux_irq_trio`

## Requirements
- R1: After reset, every status bit and every enable bit is 0, `rd_data` reads 0, and `irq` and `xfer_end` are low.
- R2: A pulse on `evt[s]` sets that source's status bit one clock later, and the bit stays set after the pulse ends. The status bit positions in `rd_data` are fixed: done (s=0) at bit 3, bad address (s=1) at 6, timeout (s=2) at 9, NACK/defer (s=3) at 12, bad byte count (s=4) at 15, and general channel error (s=5) at 27.
- R3: A write with bit P+1 at 1, where P is a source's status position, clears that source's status bit at the same clock edge. A write with bit P+1 at 0 leaves the status bit unchanged.
- R4: Every write loads bit P+2 of `wr_data` into that source's enable. A 1 enables the source and a 0 disables it. The enable reads back at bit P+2 of `rd_data` and holds between writes.
- R5: A status bit sets even while its source is disabled. `irq` is high exactly when some source has both its status bit and its enable bit set.
- R6: When an event pulse and a clear strobe for the same source arrive in the same cycle, the status bit ends up set.
- R7: The clear positions (P+1) and every bit that belongs to no source always read as 0, even after writing all ones.
- R8: `xfer_end` is high exactly when at least one of the six status bits is set, regardless of the enables.
- R9: One write acts on all sources at once. Each source is cleared and enabled or disabled according to its own bits, with no effect on the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt | input | 6 | Event pulses, index = source number |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data in the triplet layout |
| rd_data | output | 32 | Current status and enable bits |
| irq | output | 1 | Level interrupt |
| xfer_end | output | 1 | Done or any failure is latched |

## Verification
The bench drives a clear strobe and an event at the same time. A design that gives the clear priority would lose the event, so the status bit and `irq` would read 0. It also writes all ones and all zeros. This exposes a design that echoes clear strobes or unused bits on reads, and one that treats a 0 in an enable position as "leave unchanged" instead of "disable". Events that arrive while their source is disabled must still reach `xfer_end` and then raise `irq` as soon as the source is enabled. A design that gates latching with the enable would keep both low. Random mixes of writes and events hitting several sources at once catch any clear or enable that spills into a neighbouring triplet.

// File: rtl/aux_irq_pkg.sv
package aux_irq_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned SRC_N = 6;
  localparam int unsigned ACK_OFS = 1;
  localparam int unsigned EN_OFS  = 2;

  // status bit position of each source; software decodes these positions
  function automatic int unsigned stat_pos(int unsigned s);
    case (s)
      0: return 3;
      1: return 6;
      2: return 9;
      3: return 12;
      4: return 15;
      default: return 27;
    endcase
  endfunction

  // bits at status position + ofs for every source
  function automatic logic [REG_W-1:0] lane_bits(int unsigned ofs);
    logic [REG_W-1:0] m;
    m = '0;
    for (int unsigned s = 0; s < SRC_N; s++) m[stat_pos(s) + ofs] = 1'b1;
    return m;
  endfunction

  // interrupt level: any source both latched and enabled
  function automatic logic irq_level(logic [SRC_N-1:0] st, logic [SRC_N-1:0] en);
    return |(st & en);
  endfunction
endpackage

// File: rtl/irq_trio_cell.sv
module irq_trio_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic wr_en,
  input  logic ack_in,
  input  logic en_in,
  output logic stat_q,
  output logic en_q,
  output logic set_hit,
  output logic ack_hit
);
  assign set_hit = evt;
  assign ack_hit = wr_en & ack_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (set_hit)      stat_q <= 1'b1;   // event wins over clear
      else if (ack_hit) stat_q <= 1'b0;
      if (wr_en) en_q <= en_in;
    end
  end
endmodule

// File: rtl/irq_reg_pack.sv
module irq_reg_pack
  import aux_irq_pkg::*;
#(
  parameter int unsigned W = REG_W,
  parameter int unsigned N = SRC_N
) (
  input  logic [N-1:0] stat,
  input  logic [N-1:0] en,
  output logic [W-1:0] rd
);
  always_comb begin
    rd = '0;
    for (int unsigned s = 0; s < N; s++) begin
      rd[stat_pos(s)]          = stat[s];
      rd[stat_pos(s) + EN_OFS] = en[s];
    end
  end
endmodule

// File: rtl/irq_merge.sv
module irq_merge
  import aux_irq_pkg::*;
#(
  parameter int unsigned N = SRC_N
) (
  input  logic [N-1:0] stat,
  input  logic [N-1:0] en,
  output logic         irq,
  output logic         xfer_end
);
  assign irq      = irq_level(stat, en);
  assign xfer_end = |stat;
endmodule

// File: rtl/aux_irq_trio.sv
module aux_irq_trio
  import aux_irq_pkg::*;
#(
  parameter int unsigned W = REG_W,
  parameter int unsigned N = SRC_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic         irq,
  output logic         xfer_end
);
  logic [N-1:0] stat_q;
  logic [N-1:0] en_q;
  logic [N-1:0] set_hit;
  logic [N-1:0] ack_hit;

  for (genvar s = 0; s < N; s++) begin : g_src
    localparam int unsigned P = stat_pos(s);
    irq_trio_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt[s]),
      .wr_en  (wr_en),
      .ack_in (wr_data[P + ACK_OFS]),
      .en_in  (wr_data[P + EN_OFS]),
      .stat_q (stat_q[s]),
      .en_q   (en_q[s]),
      .set_hit(set_hit[s]),
      .ack_hit(ack_hit[s])
    );
  end

  irq_reg_pack #(.W(W), .N(N)) u_pack (
    .stat(stat_q),
    .en  (en_q),
    .rd  (rd_data)
  );

  irq_merge #(.N(N)) u_merge (
    .stat    (stat_q),
    .en      (en_q),
    .irq     (irq),
    .xfer_end(xfer_end)
  );
endmodule

// File: rtl/aux_irq_trio_chk.sv
module aux_irq_trio_chk
  import aux_irq_pkg::*;
#(
  parameter int unsigned W = REG_W,
  parameter int unsigned N = SRC_N
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] evt,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] rd_data,
  input logic         irq,
  input logic         xfer_end,
  input logic [N-1:0] set_hit,
  input logic [N-1:0] ack_hit
);
  localparam logic [W-1:0] STAT_M = lane_bits(0);
  localparam logic [W-1:0] EN_M   = lane_bits(EN_OFS);

  logic [N-1:0] rd_st, rd_en;
  always_comb begin
    for (int unsigned s = 0; s < N; s++) begin
      rd_st[s] = rd_data[stat_pos(s)];
      rd_en[s] = rd_data[stat_pos(s) + EN_OFS];
    end
  end

  for (genvar s = 0; s < N; s++) begin : g_chk
    localparam int unsigned P = stat_pos(s);
    a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
      evt[s] |=> rd_data[P]);
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[P] && !ack_hit[s] |=> rd_data[P]);
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ack_hit[s] && !set_hit[s] |=> !rd_data[P]);
    a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[P] && !evt[s] |=> !rd_data[P]);
    a_r6_evt_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
      set_hit[s] && ack_hit[s] |=> rd_data[P]);
    a_r4_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(rd_data[P + EN_OFS]));
  end

  a_r4_en_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data & EN_M) == ($past(wr_data) & EN_M));
  a_r7_quiet_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~(STAT_M | EN_M)) == '0);
  a_r5_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(rd_st & rd_en));
  a_r8_xfer_end: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end == (rd_st != '0));
endmodule

bind aux_irq_trio aux_irq_trio_chk #(.W(W), .N(N)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .evt     (evt),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .irq     (irq),
  .xfer_end(xfer_end),
  .set_hit (set_hit),
  .ack_hit (ack_hit)
);

// File: tb/sim_aux_irq_trio.sv
`timescale 1ns/1ps
module sim_aux_irq_trio;
  localparam int NS = 6;
  localparam int BASE [NS] = '{3, 6, 9, 12, 15, 27};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NS-1:0] evt = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq, xfer_end;

  always #10 clk = ~clk;

  aux_irq_trio u0 (
    .clk(clk), .rst_n(rst_n), .evt(evt), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .xfer_end(xfer_end)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [NS-1:0] m_st = '0;
  logic [NS-1:0] m_en = '0;

  function automatic logic [31:0] model_word(logic [NS-1:0] st, logic [NS-1:0] en);
    logic [31:0] w = '0;
    for (int k = 0; k < NS; k++) begin
      w[BASE[k]]     = st[k];
      w[BASE[k] + 2] = en[k];
    end
    return w;
  endfunction

  function automatic logic [31:0] trip(int k, bit st, bit ack, bit en);
    logic [31:0] w = '0;
    w[BASE[k]] = st; w[BASE[k] + 1] = ack; w[BASE[k] + 2] = en;
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check({req, " rd_data"}, rd_data, model_word(m_st, m_en));
    check({req, " irq"}, {31'b0, irq}, {31'b0, |(m_st & m_en)});
    check({req, " xfer_end"}, {31'b0, xfer_end}, {31'b0, m_st != '0});
  endtask

  // one clock: drive at negedge, update the model at the edge, sample later
  task automatic step(logic [NS-1:0] e, logic we, logic [31:0] wd);
    @(negedge clk);
    evt = e; wr_en = we; wr_data = wd;
    @(posedge clk);
    for (int k = 0; k < NS; k++) begin
      if (e[k]) m_st[k] = 1'b1;
      else if (we && wd[BASE[k] + 1]) m_st[k] = 1'b0;
      if (we) m_en[k] = wd[BASE[k] + 2];
    end
    #5;
    evt = '0; wr_en = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] all_ack;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    step('0, 1'b0, '0);
    check_all("R1 idle after reset");

    // R2: each source alone, masked: sets and sticks; R5 no irq while disabled
    for (int k = 0; k < NS; k++) begin
      step(NS'(1) << k, 1'b0, '0);
      check_all("R2 event latch");
      step('0, 1'b0, '0);
      check_all("R2 sticky");
    end
    // R7: write all ones -> ack everything, enable everything, quiet bits stay 0
    step('0, 1'b1, 32'hFFFF_FFFF);
    check_all("R7 all-ones write");
    check("R7 quiet bits", rd_data & ~model_word('1, '1), 32'h0);

    // R5: disabled event latches, enabling raises irq
    step('0, 1'b1, 32'h0);
    step(6'b000100, 1'b0, '0);
    check_all("R5 latch while disabled");
    check("R8 xfer_end on timeout", {31'b0, xfer_end}, 32'h1);
    step('0, 1'b1, trip(2, 0, 0, 1));
    check_all("R5 enable raises irq");
    check("R5 irq high", {31'b0, irq}, 32'h1);

    // R3: ack bit 0 keeps status; ack bit 1 clears
    step('0, 1'b1, trip(2, 1, 0, 1));
    check_all("R3 no-ack write keeps status");
    step('0, 1'b1, trip(2, 0, 1, 1));
    check_all("R3 ack clears");

    // R6: event and ack in same cycle
    step(6'b100000, 1'b1, trip(5, 0, 1, 1));
    check_all("R6 event beats ack");
    check("R6 status bit 27", {31'b0, rd_data[27]}, 32'h1);

    // R9: one write acks several and toggles several enables
    step(6'b011011, 1'b0, '0);
    all_ack = trip(0, 0, 1, 0) | trip(1, 0, 1, 1) | trip(3, 0, 0, 1) | trip(4, 0, 1, 1);
    step('0, 1'b1, all_ack);
    check_all("R9 multi-source write");

    // R4: writing 0 at enable position disables
    step('0, 1'b1, 32'h0);
    check_all("R4 zero write disables");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [NS-1:0] e;
      logic we;
      e  = NS'($urandom & $urandom);
      we = ($urandom % 3) == 0;
      step(e, we, $urandom);
      check_all("R2 R3 R4 R5 R6 R8 random");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule